// File: doc/BRIEF.md
# Line-Store FIFO Reset Pulse Generator

This block sits on a 10-bit parallel video word stream and produces an active-low, one-word strobe that a line-store FIFO further down the path can use to realign itself once per line. The stream passes through a single output register. The strobe is registered in the same stage, so it goes low in exactly the cycle in which the marker's identification word appears on the data output.

Two stream formats are supported. In component mode each line carries two timing markers, one at the end of active video and one at its start. Each marker is one all-ones word followed by two all-zeros words and then an ID word. Bit 6 of that ID word is set for the end-of-active marker and clear for the start-of-active marker. A select input chooses which of the two markers drives the strobe. In composite mode a line carries one marker, made of an all-ones word and three all-zeros words followed by its ID word. The strobe lands on that ID word and the select input is not used. The block does not check marker contents, and it keeps no line or sample count.

Top module: `lsf_reset_gen`

## Requirements
- R1: While reset is low, `vid_out` is 0 and `fifo_rst_n` is 1. Reset also clears the stored history of words, so a marker that was cut by reset produces no strobe.
- R2: `vid_out` equals the `vid_in` value of the previous clock cycle.
- R3: With `composite_mode`=0 and `eav_align`=1, `fifo_rst_n` is 0 in the cycle that `vid_out` shows an ID word with bit 6 = 1, when that word follows 3FF, 000, 000.
- R4: With `composite_mode`=0 and `eav_align`=0, `fifo_rst_n` is 0 in the cycle that `vid_out` shows an ID word with bit 6 = 0, when that word follows 3FF, 000, 000.
- R5: In component mode, the ID word of the marker that was not selected leaves `fifo_rst_n` at 1.
- R6: With `composite_mode`=1, `fifo_rst_n` is 0 in the cycle that `vid_out` shows the word following 3FF, 000, 000, 000, whatever the value of `eav_align`.
- R7: In composite mode, a shorter sequence 3FF, 000, 000, X, where X is not zero, gives no strobe.
- R8: The strobe lasts exactly one word. `fifo_rst_n` is 1 in every cycle that is not a strobe.
- R9: A broken preamble, in which a nonzero word replaces one of the zeros, gives no strobe.
- R10: In component mode only bit 6 of the ID word decides whether it is end-of-active or start-of-active. The other ID bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vid_in | input | 10 | Incoming video word |
| composite_mode | input | 1 | 1 = composite stream (single marker per line), 0 = component |
| eav_align | input | 1 | Component only: 1 = strobe on end-of-active ID, 0 = on start-of-active ID |
| vid_out | output | 10 | Video word delayed by one clock |
| fifo_rst_n | output | 1 | Active-low one-word FIFO realignment strobe |

## Verification
The bench builds the block with its default parameters: a 10-bit word, the marker side flag in bit 6, two zero words in the component preamble and three in the composite one. With these values, the bench can place composite and component preambles side by side in one stream, which lets it check that a component-length preamble does not fire in composite mode. It also covers ID words that differ from each other only in bit 6 or only outside it, and a reset that lands in the middle of a preamble.

// File: rtl/lsf_reset_pkg.sv
package lsf_reset_pkg;

    typedef enum logic {
        MODE_COMPONENT = 1'b0,
        MODE_COMPOSITE = 1'b1
    } vid_mode_e;

    // Marker detection results for the word currently at the input.
    typedef struct packed {
        logic comp_marker;   // preamble of the two-marker (component) format seen
        logic comp_is_eav;   // side flag carried by the component ID word
        logic cvbs_marker;   // preamble of the single-marker (composite) format seen
    } marker_hit_t;

endpackage

// File: rtl/lsf_word_history.sv
module lsf_word_history #(
    parameter int DW    = 10,
    parameter int DEPTH = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [DW-1:0]               word_in,
    output logic [DEPTH-1:0][DW-1:0]    hist
);

    typedef logic [DEPTH-1:0][DW-1:0] hist_t;

    typedef struct packed {
        hist_t w;
    } hist_state_t;

    hist_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.w[0] = word_in;
        for (int i = 1; i < DEPTH; i++) begin
            st_d.w[i] = st_q.w[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hist = st_q.w;

endmodule

// File: rtl/lsf_marker_match.sv
module lsf_marker_match
    import lsf_reset_pkg::*;
#(
    parameter int DW    = 10,
    parameter int ZCOMP = 2,
    parameter int ZCVBS = 3,
    localparam int DEPTH = ZCVBS + 1
) (
    input  logic [DEPTH-1:0][DW-1:0] hist,
    input  logic                     side_bit,
    output marker_hit_t              hit
);

    logic [ZCVBS-1:0] zero_flag;

    generate
        for (genvar g = 0; g < ZCVBS; g++) begin : g_zero
            assign zero_flag[g] = (hist[g] == '0);
        end
    endgenerate

    logic comp_ones;
    logic cvbs_ones;

    assign comp_ones = (hist[ZCOMP] == '1);
    assign cvbs_ones = (hist[ZCVBS] == '1);

    always_comb begin
        hit             = '0;
        hit.comp_marker = comp_ones && (&zero_flag[ZCOMP-1:0]);
        hit.cvbs_marker = cvbs_ones && (&zero_flag);
        hit.comp_is_eav = side_bit;
    end

endmodule

// File: rtl/lsf_pulse_pick.sv
module lsf_pulse_pick
    import lsf_reset_pkg::*;
(
    input  marker_hit_t hit,
    input  vid_mode_e   mode,
    input  logic        eav_sel,
    output logic        fire
);

    always_comb begin
        fire = 1'b0;
        case (mode)
            MODE_COMPONENT: fire = hit.comp_marker && (hit.comp_is_eav == eav_sel);
            MODE_COMPOSITE: fire = hit.cvbs_marker;
            default:        fire = 1'b0;
        endcase
    end

endmodule

// File: rtl/lsf_reset_gen.sv
module lsf_reset_gen
    import lsf_reset_pkg::*;
#(
    parameter int DW    = 10,
    parameter int HBIT  = 6,
    parameter int ZCOMP = 2,
    parameter int ZCVBS = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] vid_in,
    input  logic          composite_mode,
    input  logic          eav_align,
    output logic [DW-1:0] vid_out,
    output logic          fifo_rst_n
);

    localparam int DEPTH = ZCVBS + 1;

    logic [DEPTH-1:0][DW-1:0] hist;
    marker_hit_t              hit;
    vid_mode_e                mode;
    logic                     fire;

    assign mode = vid_mode_e'(composite_mode);

    lsf_word_history #(.DW(DW), .DEPTH(DEPTH)) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .word_in (vid_in),
        .hist    (hist)
    );

    lsf_marker_match #(.DW(DW), .ZCOMP(ZCOMP), .ZCVBS(ZCVBS)) u_match (
        .hist     (hist),
        .side_bit (vid_in[HBIT]),
        .hit      (hit)
    );

    lsf_pulse_pick u_pick (
        .hit     (hit),
        .mode    (mode),
        .eav_sel (eav_align),
        .fire    (fire)
    );

    typedef struct packed {
        logic [DW-1:0] data;
        logic          strobe_n;
    } out_state_t;

    out_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.data     = vid_in;
        st_d.strobe_n = !fire;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.data     <= '0;
            st_q.strobe_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign vid_out    = st_q.data;
    assign fifo_rst_n = st_q.strobe_n;

    // R2
    dout_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (vid_out == $past(vid_in)));

    // R8
    pulse_one_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_rst_n |=> fifo_rst_n);

    // R3 R4
    marker_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_rst_n && !$past(composite_mode)) |-> (vid_out[HBIT] == $past(eav_align)));

    // R6
    cvbs_prev_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_rst_n && $past(composite_mode)) |-> ($past(vid_out) == '0));

endmodule

// File: tb/lsf_reset_gen_test.sv
`timescale 1ns/1ps
module lsf_reset_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] vid_in = '0;
    logic       composite_mode = 1'b0;
    logic       eav_align = 1'b0;
    logic [9:0] vid_out;
    logic       fifo_rst_n;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    lsf_reset_gen uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .vid_in         (vid_in),
        .composite_mode (composite_mode),
        .eav_align      (eav_align),
        .vid_out        (vid_out),
        .fifo_rst_n     (fifo_rst_n)
    );

    // {tag, composite, eav_align, word, strobe expected}
    localparam int NV = 50;
    localparam logic [16:0] VEC [NV] = '{
        {4'd8, 1'b0, 1'b1, 10'h040, 1'b0},
        {4'd8, 1'b0, 1'b1, 10'h3FF, 1'b0},
        {4'd8, 1'b0, 1'b1, 10'h000, 1'b0},
        {4'd8, 1'b0, 1'b1, 10'h000, 1'b0},
        {4'd3, 1'b0, 1'b1, 10'h274, 1'b1},
        {4'd8, 1'b0, 1'b1, 10'h200, 1'b0},
        {4'd8, 1'b0, 1'b1, 10'h3FF, 1'b0},
        {4'd8, 1'b0, 1'b1, 10'h000, 1'b0},
        {4'd8, 1'b0, 1'b1, 10'h000, 1'b0},
        {4'd5, 1'b0, 1'b1, 10'h2AC, 1'b0},
        {4'd8, 1'b0, 1'b0, 10'h3FF, 1'b0},
        {4'd8, 1'b0, 1'b0, 10'h000, 1'b0},
        {4'd8, 1'b0, 1'b0, 10'h000, 1'b0},
        {4'd4, 1'b0, 1'b0, 10'h2AC, 1'b1},
        {4'd8, 1'b0, 1'b0, 10'h3FF, 1'b0},
        {4'd8, 1'b0, 1'b0, 10'h000, 1'b0},
        {4'd8, 1'b0, 1'b0, 10'h000, 1'b0},
        {4'd5, 1'b0, 1'b0, 10'h274, 1'b0},
        {4'd8, 1'b0, 1'b1, 10'h3FF, 1'b0},
        {4'd8, 1'b0, 1'b1, 10'h000, 1'b0},
        {4'd8, 1'b0, 1'b1, 10'h000, 1'b0},
        {4'd10, 1'b0, 1'b1, 10'h040, 1'b1},
        {4'd8, 1'b0, 1'b0, 10'h3FF, 1'b0},
        {4'd8, 1'b0, 1'b0, 10'h000, 1'b0},
        {4'd8, 1'b0, 1'b0, 10'h000, 1'b0},
        {4'd10, 1'b0, 1'b0, 10'h3BF, 1'b1},
        {4'd8, 1'b0, 1'b1, 10'h3FF, 1'b0},
        {4'd8, 1'b0, 1'b1, 10'h000, 1'b0},
        {4'd8, 1'b0, 1'b1, 10'h155, 1'b0},
        {4'd9, 1'b0, 1'b1, 10'h274, 1'b0},
        {4'd8, 1'b0, 1'b1, 10'h3FF, 1'b0},
        {4'd8, 1'b0, 1'b1, 10'h3FF, 1'b0},
        {4'd8, 1'b0, 1'b1, 10'h000, 1'b0},
        {4'd8, 1'b0, 1'b1, 10'h000, 1'b0},
        {4'd3, 1'b0, 1'b1, 10'h274, 1'b1},
        {4'd8, 1'b1, 1'b1, 10'h3FF, 1'b0},
        {4'd8, 1'b1, 1'b1, 10'h000, 1'b0},
        {4'd8, 1'b1, 1'b1, 10'h000, 1'b0},
        {4'd8, 1'b1, 1'b1, 10'h000, 1'b0},
        {4'd6, 1'b1, 1'b1, 10'h155, 1'b1},
        {4'd8, 1'b1, 1'b0, 10'h3FF, 1'b0},
        {4'd8, 1'b1, 1'b0, 10'h000, 1'b0},
        {4'd8, 1'b1, 1'b0, 10'h000, 1'b0},
        {4'd8, 1'b1, 1'b0, 10'h000, 1'b0},
        {4'd6, 1'b1, 1'b0, 10'h2AA, 1'b1},
        {4'd8, 1'b1, 1'b1, 10'h3FF, 1'b0},
        {4'd8, 1'b1, 1'b1, 10'h000, 1'b0},
        {4'd8, 1'b1, 1'b1, 10'h000, 1'b0},
        {4'd7, 1'b1, 1'b1, 10'h274, 1'b0},
        {4'd8, 1'b1, 1'b1, 10'h100, 1'b0}
    };

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd9:    return "R9";
            4'd10:   return "R10";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [9:0] act, input logic [9:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic c, input logic s, input logic [9:0] d);
        composite_mode = c;
        eav_align      = s;
        vid_in         = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: outputs during reset
        vid_in = 10'h3FF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "vid_out in reset", vid_out, 10'h000);
        check("R1", "fifo_rst_n in reset", {9'b0, fifo_rst_n}, 10'h001);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [16:0] v;
            v = VEC[i];
            step(v[12], v[11], v[10:1]);
            check(tag_name(v[16:13]), "strobe", {9'b0, fifo_rst_n}, {9'b0, !v[0]});
            check("R2", "vid_out", vid_out, v[10:1]);
        end

        // R1: reset in the middle of a component preamble clears history
        step(1'b0, 1'b1, 10'h3FF);
        step(1'b0, 1'b1, 10'h000);
        step(1'b0, 1'b1, 10'h000);
        rst_n = 1'b0;
        step(1'b0, 1'b1, 10'h000);
        check("R1", "vid_out after mid-preamble reset", vid_out, 10'h000);
        check("R1", "fifo_rst_n after mid-preamble reset", {9'b0, fifo_rst_n}, 10'h001);
        rst_n = 1'b1;
        step(1'b0, 1'b1, 10'h274);
        check("R1", "no strobe on ID after reset", {9'b0, fifo_rst_n}, 10'h001);
        check("R2", "vid_out after reset release", vid_out, 10'h274);

        // R8: strobe high again on the word after the ID
        step(1'b0, 1'b0, 10'h3FF);
        step(1'b0, 1'b0, 10'h000);
        step(1'b0, 1'b0, 10'h000);
        step(1'b0, 1'b0, 10'h200);
        check("R4", "strobe on start-of-active ID", {9'b0, fifo_rst_n}, 10'h000);
        step(1'b0, 1'b0, 10'h000);
        check("R8", "strobe released after one word", {9'b0, fifo_rst_n}, 10'h001);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule